// File: doc/BRIEF.md
# Output Driver Fault Latch

This block sits between the protection sensors of a bank of output drivers and the serial control interface that a host uses to read them. Each output can raise over-current and open-load events, and the die can raise thermal-warning and thermal-shutdown events. All of these arrive as digitized pulses. The block captures them into two status words that stay set until the host clears them, and it turns them into per-output inhibit lines and a global high-impedance request for the power stage.

A single control-interface side feeds the block. It sends a pulse when a frame ends, a flag that says the frame had the right length, and the clear-all bit taken from that frame. A clear takes effect only on a well-formed frame and only at its end. A summary fault bit sits in bit 0 of both status words. The same bit is driven on the serial data line as soon as chip select goes low, with no clock pulse needed.

The outputs stay inhibited after reset until the first well-formed frame arrives. From then on, an over-current holds its output off until it is cleared. If recovery is enabled for that output, the hold lasts only while the event stays present.

Top module: `drv_fault_latch`

## Requirements
- R1: After reset both status words read 1 (only the summary bit set), every output is inhibited, the high-impedance request is 0, the summary flag is 1 and the serial line is disabled while chip select is high.
- R2: An event pulse sets its status bit on the next clock edge. Word A bit i+1 is the over-current of output i, bit NUM_OUT+1 is the thermal warning and bit NUM_OUT+2 is the thermal shutdown. Word B bit i+1 is the open-load of output i. All other upper bits read 0.
- R3: Bit 0 of both words and the summary flag output are 1 exactly when no event bit is set in either word.
- R4: With recovery off for an output, an over-current inhibits that output from the next edge until a valid clear, even after the event input has gone low.
- R5: With recovery on for an output, the inhibit follows the over-current input delayed by one cycle, while the status bit stays latched until it is cleared.
- R6: A thermal shutdown raises the high-impedance request on the next edge and holds it until a valid clear.
- R7: A clear is applied only when a frame end pulse arrives with the frame-valid flag and the clear bit both high. It then zeroes both words on that edge. A frame end that is not valid leaves the status unchanged.
- R8: An event that arrives in the same cycle as a clear remains set after the clear.
- R9: Every output stays inhibited until the first frame end that has the frame-valid flag high. After that, the inhibit comes only from over-current.
- R10: While chip select is low the serial enable is 1 and the serial data equals the summary bit, with no clock needed. While chip select is high both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ocEvt | input | NUM_OUT | Over-current event per output |
| olEvt | input | NUM_OUT | Open-load event per output |
| twEvt | input | 1 | Thermal warning event |
| tsdEvt | input | 1 | Thermal shutdown event |
| recovEn | input | NUM_OUT | Per-output over-current recovery enable |
| frameEnd | input | 1 | One-cycle pulse at the end of a serial frame |
| frameOk | input | 1 | Ending frame had the correct bit count |
| clrReq | input | 1 | Clear-all bit of the ending frame |
| csN | input | 1 | Chip select, active low |
| statA | output | STAT_W | Status word A (over-current, thermal) |
| statB | output | STAT_W | Status word B (open load) |
| outInhibit | output | NUM_OUT | Per-output driver disable |
| hiZ | output | 1 | Force all outputs to high impedance |
| nFault | output | 1 | Summary bit, low when any event is latched |
| sdoEn | output | 1 | Serial data output enable |
| sdo | output | 1 | Serial data output value |

## Verification
The hardest case to reach is a clear and a new event on the same edge. The bench drives a valid clear frame in exactly the cycle an open-load pulse arrives, with an older over-current still latched. It then checks that only the new bit survives. The recovery path needs the over-current input held for several cycles and then dropped, while the status bit is watched to confirm it stays set. Clear frames marked invalid are mixed in to confirm they leave the status untouched.

// File: rtl/faultlatch_pkg.sv
package faultlatch_pkg;
  // Strobes from control to the status store
  typedef struct packed {
    logic clrAll;  // apply clear-all on this edge
    logic arm;     // well-formed frame ended
  } faultStrobe_t;
endpackage

// File: rtl/fault_ctrl.sv
module fault_ctrl
  import faultlatch_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         frameEnd,
  input  logic         frameOk,
  input  logic         clrReq,
  input  logic         csN,
  input  logic         summaryBit,
  output faultStrobe_t strobe,
  output logic         armed,
  output logic         sdoEn,
  output logic         sdo
);
  always_comb begin
    strobe.arm    = frameEnd & frameOk;
    strobe.clrAll = frameEnd & frameOk & clrReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          armed <= 1'b0;
    else if (strobe.arm) armed <= 1'b1;
  end

  assign sdoEn = ~csN;
  assign sdo   = ~csN & summaryBit;

  // R9: once armed, stays armed
  p_arm_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    armed |=> armed);
  // R9: arming only after a well-formed frame end
  p_arm_needs_frame_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!armed && !(frameEnd && frameOk)) |=> !armed);
  // R10: serial line quiet when not selected
  p_sdo_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (!sdoEn && !sdo));
endmodule

// File: rtl/fault_store.sv
module fault_store
  import faultlatch_pkg::*;
#(
  parameter int NUM_OUT = 11,
  parameter int STAT_W  = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_OUT-1:0] ocEvt,
  input  logic [NUM_OUT-1:0] olEvt,
  input  logic               twEvt,
  input  logic               tsdEvt,
  input  logic [NUM_OUT-1:0] recovEn,
  input  faultStrobe_t       strobe,
  input  logic               armed,
  output logic [STAT_W-1:0]  statA,
  output logic [STAT_W-1:0]  statB,
  output logic [NUM_OUT-1:0] outInhibit,
  output logic               hiZ,
  output logic               nFault
);
  localparam int TW_POS  = NUM_OUT + 1;
  localparam int TSD_POS = NUM_OUT + 2;

  logic [NUM_OUT-1:0] ocLat, olLat, ocNow;
  logic               twLat, tsdLat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ocLat  <= '0;
      olLat  <= '0;
      ocNow  <= '0;
      twLat  <= 1'b0;
      tsdLat <= 1'b0;
    end else begin
      ocLat  <= (strobe.clrAll ? '0   : ocLat)  | ocEvt;
      olLat  <= (strobe.clrAll ? '0   : olLat)  | olEvt;
      twLat  <= (strobe.clrAll ? 1'b0 : twLat)  | twEvt;
      tsdLat <= (strobe.clrAll ? 1'b0 : tsdLat) | tsdEvt;
      ocNow  <= ocEvt;
    end
  end

  assign nFault = ~(|ocLat | |olLat | twLat | tsdLat);
  assign hiZ    = tsdLat;

  always_comb begin
    statA = '0;
    statB = '0;
    statA[0] = nFault;
    statB[0] = nFault;
    statA[TW_POS]  = twLat;
    statA[TSD_POS] = tsdLat;
    for (int i = 0; i < NUM_OUT; i++) begin
      statA[i+1] = ocLat[i];
      statB[i+1] = olLat[i];
    end
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : gOut
    assign outInhibit[g] = ~armed | (recovEn[g] ? ocNow[g] : ocLat[g]);

    // R8: a new event is visible after the edge, even with a clear
    p_evt_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
      ocEvt[g] |=> statA[g+1]);
    // R4: latched over-current without recovery keeps the output off
    p_oc_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
      (statA[g+1] && !recovEn[g]) |-> outInhibit[g]);
    // R7: a clear with no new event drops the bit
    p_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.clrAll && !ocEvt[g]) |=> !statA[g+1]);
  end

  // R6: shutdown raises high impedance
  p_tsd_hiz_r6: assert property (@(posedge clk) disable iff (!rstN)
    tsdEvt |=> hiZ);
  // R3: summary high only when no event bit set
  p_summary_r3: assert property (@(posedge clk) disable iff (!rstN)
    nFault |-> (statA[STAT_W-1:1] == '0 && statB[STAT_W-1:1] == '0));
endmodule

// File: rtl/drv_fault_latch.sv
module drv_fault_latch
  import faultlatch_pkg::*;
#(
  parameter int NUM_OUT = 11,
  parameter int STAT_W  = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_OUT-1:0] ocEvt,
  input  logic [NUM_OUT-1:0] olEvt,
  input  logic               twEvt,
  input  logic               tsdEvt,
  input  logic [NUM_OUT-1:0] recovEn,
  input  logic               frameEnd,
  input  logic               frameOk,
  input  logic               clrReq,
  input  logic               csN,
  output logic [STAT_W-1:0]  statA,
  output logic [STAT_W-1:0]  statB,
  output logic [NUM_OUT-1:0] outInhibit,
  output logic               hiZ,
  output logic               nFault,
  output logic               sdoEn,
  output logic               sdo
);
  faultStrobe_t strobe;
  logic         armed;

  fault_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .frameEnd(frameEnd), .frameOk(frameOk),
    .clrReq(clrReq), .csN(csN), .summaryBit(nFault), .strobe(strobe),
    .armed(armed), .sdoEn(sdoEn), .sdo(sdo)
  );

  fault_store #(.NUM_OUT(NUM_OUT), .STAT_W(STAT_W)) i_store (
    .clk(clk), .rstN(rstN), .ocEvt(ocEvt), .olEvt(olEvt), .twEvt(twEvt),
    .tsdEvt(tsdEvt), .recovEn(recovEn), .strobe(strobe), .armed(armed),
    .statA(statA), .statB(statB), .outInhibit(outInhibit), .hiZ(hiZ),
    .nFault(nFault)
  );
endmodule

// File: tb/test_drv_fault_latch.sv
module test_drv_fault_latch;
  localparam int CLK_PERIOD = 10;
  localparam int N = 11;
  localparam int W = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] ocEvt = '0, olEvt = '0, recovEn = '0;
  logic twEvt = 1'b0, tsdEvt = 1'b0;
  logic frameEnd = 1'b0, frameOk = 1'b0, clrReq = 1'b0, csN = 1'b1;
  logic [W-1:0] statA, statB;
  logic [N-1:0] outInhibit;
  logic hiZ, nFault, sdoEn, sdo;

  always #(CLK_PERIOD/2) clk = ~clk;

  drv_fault_latch #(.NUM_OUT(N), .STAT_W(W)) i_drv_fault_latch (
    .clk(clk), .rstN(rstN), .ocEvt(ocEvt), .olEvt(olEvt), .twEvt(twEvt),
    .tsdEvt(tsdEvt), .recovEn(recovEn), .frameEnd(frameEnd),
    .frameOk(frameOk), .clrReq(clrReq), .csN(csN), .statA(statA),
    .statB(statB), .outInhibit(outInhibit), .hiZ(hiZ), .nFault(nFault),
    .sdoEn(sdoEn), .sdo(sdo)
  );

  typedef struct {
    string       tag;
    int          fld;
    logic [31:0] v;
  } item_t;
  item_t q[$];
  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  function automatic logic [31:0] actual(int fld);
    case (fld)
      0: return 32'(statA);
      1: return 32'(statB);
      2: return 32'(outInhibit);
      3: return 32'(hiZ);
      4: return 32'(nFault);
      5: return 32'(sdoEn);
      default: return 32'(sdo);
    endcase
  endfunction

  // push an expectation for the state after the coming clock edge
  task automatic expectV(string tag, int fld, logic [31:0] v);
    item_t it;
    it.tag = tag; it.fld = fld; it.v = v;
    q.push_back(it);
  endtask

  task automatic expectWords(string tag, logic [31:0] a, logic [31:0] b);
    logic s;
    s = (a[31:1] == 0) && (b[31:1] == 0);  // R3 summary rule
    expectV(tag, 0, a | 32'(s));
    expectV(tag, 1, b | 32'(s));
    expectV(tag, 4, 32'(s));
  endtask

  // monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] a;
        it = q.pop_front();
        a = actual(it.fld);
        compared++;
        if (a !== it.v) begin
          mismatched++;
          $display("FAIL %s field %0d actual %h expected %h", it.tag, it.fld, a, it.v);
        end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    frameEnd = 1'b0; frameOk = 1'b0; clrReq = 1'b0;
    ocEvt = '0; olEvt = '0; twEvt = 1'b0; tsdEvt = 1'b0;
  endtask

  initial begin
    // R1: reset state
    @(negedge clk);
    expectWords("R1 reset", 32'h0, 32'h0);
    expectV("R1 inhibit", 2, 32'h7FF);
    expectV("R1 hiZ", 3, 0);
    expectV("R1 sdoEn", 5, 0);
    expectV("R1 sdo", 6, 0);
    @(negedge clk);
    rstN = 1'b1;
    // R9: invalid frame end does not arm
    frameEnd = 1'b1; frameOk = 1'b0;
    expectV("R9 not armed", 2, 32'h7FF);
    tick();
    frameEnd = 1'b1; frameOk = 1'b1;
    expectV("R9 armed", 2, 32'h0);
    tick();
    // R10: summary on serial line without clocking
    csN = 1'b0;
    expectV("R10 sdoEn", 5, 1);
    expectV("R10 sdo", 6, 1);
    tick();
    // R2, R3: over-current on output 2, no recovery
    ocEvt[2] = 1'b1;
    expectWords("R2 oc bit", 32'h8, 32'h0);
    expectV("R4 inhibit set", 2, 32'h4);
    expectV("R10 sdo fault", 6, 0);
    tick();
    expectV("R4 inhibit held", 2, 32'h4);
    tick();
    // R7: invalid clear ignored
    frameEnd = 1'b1; frameOk = 1'b0; clrReq = 1'b1;
    expectWords("R7 invalid clear", 32'h8, 32'h0);
    expectV("R4 still held", 2, 32'h4);
    tick();
    // R7: valid clear
    frameEnd = 1'b1; frameOk = 1'b1; clrReq = 1'b1;
    expectWords("R7 valid clear", 32'h0, 32'h0);
    expectV("R7 inhibit released", 2, 32'h0);
    tick();
    // R5: recovery on output 5
    recovEn[5] = 1'b1;
    ocEvt[5] = 1'b1;
    expectV("R5 inhibit on", 2, 32'h20);
    expectWords("R5 bit", 32'h40, 32'h0);
    @(negedge clk);
    ocEvt[5] = 1'b1;
    expectV("R5 inhibit stays", 2, 32'h20);
    tick();
    expectV("R5 inhibit off", 2, 32'h0);
    expectWords("R5 bit latched", 32'h40, 32'h0);
    tick();
    // R8: clear and new open-load on same edge
    frameEnd = 1'b1; frameOk = 1'b1; clrReq = 1'b1;
    olEvt[0] = 1'b1;
    expectWords("R8 event wins", 32'h0, 32'h2);
    tick();
    frameEnd = 1'b1; frameOk = 1'b1; clrReq = 1'b1;
    expectWords("R7 clear open load", 32'h0, 32'h0);
    tick();
    // R6: shutdown and warning
    tsdEvt = 1'b1; twEvt = 1'b1;
    expectV("R6 hiZ on", 3, 1);
    expectWords("R2 thermal bits", 32'h3000, 32'h0);
    tick();
    expectV("R6 hiZ held", 3, 1);
    tick();
    frameEnd = 1'b1; frameOk = 1'b1; clrReq = 1'b1;
    expectV("R6 hiZ cleared", 3, 0);
    expectWords("R7 thermal cleared", 32'h0, 32'h0);
    tick();
    csN = 1'b1;
    expectV("R10 deselect", 5, 0);
    expectV("R10 deselect sdo", 6, 0);
    tick();
    tick();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule